// File: doc/BRIEF.md
# Group-Two Skip and Halt Decoder

This block decodes the conditional-skip, clear and halt microinstructions of a 12-bit accumulator machine. On a decode strobe it looks at the instruction word, the current accumulator and the link bit. One clock later it presents three results together: a skip flag, a halt request and the accumulator value that results from the instruction. The skip flag tells the program counter to step over the next word. The halt request goes to the run/halt control. The accumulator result is zero when the word asks for a clear, and otherwise it is the old value unchanged.

A word takes part only when its three top bits read octal 7, bit value 0400 is set, and bit values 0004 and 0001 are both clear. Three tests can be selected: accumulator negative, accumulator zero and link set. The selected tests are ORed. A sense bit turns the result into its complement, so the skip fires only when none of the selected conditions is true. With no test selected and the sense bit set, the word becomes an unconditional skip. The clear and halt bits act in the same word as the test.

Each strobe is evaluated only on its own inputs, so strobes may arrive on back-to-back cycles. Program-counter arithmetic, the run/halt state machine and memory access are handled by other blocks.

Top module: `g2_skip_decoder`

## Requirements
- R1: `res_valid_o` is high in exactly the cycle after a cycle with `dec_stb` high. In any cycle not preceded by a strobe, `res_valid_o`, `skip_o`, `halt_o` and `acc_o` are all zero.
- R2: While `rst` is high, all outputs are zero at every clock, even if `dec_stb` is high.
- R3: A strobed word is decoded only when bits 11:9 equal octal 7, bit 8 (value 0400) is 1, and bits 2 and 0 (values 0004 and 0001) are 0. For any other word the block gives skip 0, halt 0 and `acc_o` equal to the input accumulator.
- R4: Bit 6 (value 0100) selects the accumulator-negative test, which is true when accumulator bit 11 is 1. So 7500 skips when the accumulator is negative, and 7510 skips when it is not negative.
- R5: Bit 5 (value 0040) selects the accumulator-zero test. So 7440 skips when the accumulator is zero, and 7450 skips when it is nonzero.
- R6: Bit 4 (value 0020) selects the link test, which is true when the link is 1. So 7420 skips when the link is set, and 7430 skips when the link is clear.
- R7: When more than one test is selected and bit 3 is 0, the skip is the OR of the selected tests.
- R8: Bit 3 (value 0010) inverts the sense: the skip is high only when no selected test is true. With no test selected, 7410 skips unconditionally, and 7400 never skips.
- R9: Bit 7 (value 0200) makes `acc_o` zero. The skip is still judged on the accumulator value presented with the strobe.
- R10: Bit 1 (value 0002) raises `halt_o`. The halt does not depend on the skip outcome and can appear together with it (7402 halts; 7412 halts and skips).
- R11: Strobes on consecutive cycles are each evaluated on their own inputs. With accumulator and link both zero, 7440 followed at once by 7430 gives a skip in both result cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_stb | input | 1 | Decode strobe; the inputs below are sampled in this cycle |
| instr_i | input | WORD_W | Instruction word |
| acc_i | input | WORD_W | Current accumulator |
| link_i | input | 1 | Current link bit |
| res_valid_o | output | 1 | Results valid, one cycle after the strobe |
| skip_o | output | 1 | Step over the next instruction word |
| halt_o | output | 1 | Halt request |
| acc_o | output | WORD_W | Accumulator after the instruction (cleared or unchanged) |

## Verification
Two things can land in one result cycle: a skip judged on the old accumulator, and a clear of that same accumulator. A halt can also land together with a skip. The bench provokes both cases with words such as 7640 and 7700 on a zero or negative accumulator, and with 7412, and judges them by requiring a skip while `acc_o` reads zero or `halt_o` is high. It also runs 7440 and 7430 strobes on consecutive cycles with no clear between them, to show that the second result does not depend on the first. A behavioural model in the bench predicts every output on every clock, including idle and reset cycles, across a sweep of all test and sense combinations.

// File: rtl/g2_skip_pkg.sv
package g2_skip_pkg;

  // Decoded control fields of a group-two operate word
  typedef struct packed {
    logic grp2;    // word belongs to this block
    logic t_neg;   // accumulator-negative test selected
    logic t_zero;  // accumulator-zero test selected
    logic t_link;  // link-set test selected
    logic invert;  // reverse sense of the combined test
    logic clr;     // clear accumulator after test
    logic hlt;     // halt request
  } g2_ctl_t;

endpackage

// File: rtl/g2_field_decode.sv
module g2_field_decode
  import g2_skip_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W-1:0] word,
  output g2_ctl_t           ctl
);
  // Field positions counted down from the top so they track WORD_W
  localparam int OPC_LO   = WORD_W - 3;
  localparam int GRP_BIT  = WORD_W - 4;
  localparam int CLR_BIT  = WORD_W - 5;
  localparam int NEG_BIT  = WORD_W - 6;
  localparam int ZERO_BIT = WORD_W - 7;
  localparam int LNK_BIT  = WORD_W - 8;
  localparam int INV_BIT  = WORD_W - 9;
  localparam int AUX_BIT  = 2;
  localparam int HLT_BIT  = 1;
  localparam int SEL_BIT  = 0;

  logic opc_ok;

  always_comb begin
    opc_ok     = &word[WORD_W-1:OPC_LO];
    ctl.grp2   = opc_ok & word[GRP_BIT] & ~word[AUX_BIT] & ~word[SEL_BIT];
    ctl.t_neg  = word[NEG_BIT];
    ctl.t_zero = word[ZERO_BIT];
    ctl.t_link = word[LNK_BIT];
    ctl.invert = word[INV_BIT];
    ctl.clr    = word[CLR_BIT];
    ctl.hlt    = word[HLT_BIT];
  end
endmodule

// File: rtl/g2_cond_eval.sv
module g2_cond_eval
  import g2_skip_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  g2_ctl_t           ctl,
  input  logic [WORD_W-1:0] acc,
  input  logic              link,
  output logic              skip,
  output logic              halt,
  output logic [WORD_W-1:0] acc_next
);
  localparam int SIGN_BIT = WORD_W - 1;

  logic acc_neg, acc_zero, any_true;

  always_comb begin
    acc_neg  = acc[SIGN_BIT];
    acc_zero = ~|acc;
    any_true = (ctl.t_neg & acc_neg) | (ctl.t_zero & acc_zero) | (ctl.t_link & link);
    skip     = ctl.grp2 & (ctl.invert ? ~any_true : any_true);
    halt     = ctl.grp2 & ctl.hlt;
    // test above uses the incoming value; clear applies afterwards
    acc_next = (ctl.grp2 & ctl.clr) ? '0 : acc;
  end
endmodule

// File: rtl/g2_out_reg.sv
module g2_out_reg #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              skip_d,
  input  logic              halt_d,
  input  logic [WORD_W-1:0] acc_d,
  output logic              valid_q,
  output logic              skip_q,
  output logic              halt_q,
  output logic [WORD_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      skip_q  <= 1'b0;
      halt_q  <= 1'b0;
      acc_q   <= '0;
    end else begin
      valid_q <= stb;
      skip_q  <= stb & skip_d;
      halt_q  <= stb & halt_d;
      acc_q   <= stb ? acc_d : '0;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    stb |=> valid_q);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !stb |=> (!valid_q && !skip_q && !halt_q && acc_q == '0));
endmodule

// File: rtl/g2_skip_decoder.sv
module g2_skip_decoder
  import g2_skip_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_stb,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              link_i,
  output logic              res_valid_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic [WORD_W-1:0] acc_o
);
  localparam int OPC_LO = WORD_W - 3;

  g2_ctl_t           ctl;
  logic              skip_c, halt_c;
  logic [WORD_W-1:0] acc_c;

  g2_field_decode #(.WORD_W(WORD_W)) u_dec (
    .word (instr_i),
    .ctl  (ctl)
  );

  g2_cond_eval #(.WORD_W(WORD_W)) u_eval (
    .ctl      (ctl),
    .acc      (acc_i),
    .link     (link_i),
    .skip     (skip_c),
    .halt     (halt_c),
    .acc_next (acc_c)
  );

  g2_out_reg #(.WORD_W(WORD_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .stb     (dec_stb),
    .skip_d  (skip_c),
    .halt_d  (halt_c),
    .acc_d   (acc_c),
    .valid_q (res_valid_o),
    .skip_q  (skip_o),
    .halt_q  (halt_o),
    .acc_q   (acc_o)
  );

  assert_foreign_word_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_stb && !(&instr_i[WORD_W-1:OPC_LO])) |=> (!skip_o && !halt_o && acc_o == $past(acc_i)));
  assert_zero_skip_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_stb && instr_i == WORD_W'(12'o7440) && acc_i == '0) |=> skip_o);
  assert_always_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (dec_stb && instr_i == WORD_W'(12'o7410)) |=> (skip_o && !halt_o));
  assert_clear_skip_R9: assert property (@(posedge clk) disable iff (rst)
    (dec_stb && instr_i == WORD_W'(12'o7610)) |=> (skip_o && acc_o == '0));
  assert_halt_only_R10: assert property (@(posedge clk) disable iff (rst)
    (dec_stb && instr_i == WORD_W'(12'o7402)) |=> (halt_o && !skip_o));
endmodule

// File: tb/sim_g2_skip_decoder.sv
module sim_g2_skip_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dec_stb = 1'b0;
  logic [W-1:0] instr_i = '0;
  logic [W-1:0] acc_i = '0;
  logic         link_i = 1'b0;
  logic         res_valid_o, skip_o, halt_o;
  logic [W-1:0] acc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  g2_skip_decoder #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .dec_stb(dec_stb), .instr_i(instr_i),
    .acc_i(acc_i), .link_i(link_i), .res_valid_o(res_valid_o),
    .skip_o(skip_o), .halt_o(halt_o), .acc_o(acc_o)
  );

  // Behavioural reference: arithmetic on octal digits, one call per strobe
  function automatic void model(input int w, input int a, input int l,
                                output int sk, output int hl, output int ao);
    int is2, any_t, neg, zer;
    is2   = ((w / 512) % 8 == 7) && ((w / 256) % 2 == 1) && (w % 2 == 0) && ((w / 4) % 2 == 0);
    neg   = (a >= 2048);
    zer   = (a == 0);
    any_t = (((w / 64) % 2 == 1) && neg) || (((w / 32) % 2 == 1) && zer) || (((w / 16) % 2 == 1) && (l != 0));
    if (is2) begin
      sk = ((w / 8) % 2 == 1) ? !any_t : any_t;
      hl = ((w / 2) % 2 == 1);
      ao = ((w / 128) % 2 == 1) ? 0 : a;
    end else begin
      sk = 0; hl = 0; ao = a;
    end
  endfunction

  task automatic compare(input string tag, input int ev, input int es, input int eh, input int ea);
    checks++;
    if (res_valid_o !== 1'(ev) || skip_o !== 1'(es) || halt_o !== 1'(eh) || acc_o !== W'(ea)) begin
      errors++;
      $display("FAIL %s word=%o acc=%o link=%0d: got v=%0d s=%0d h=%0d acc=%o, expected v=%0d s=%0d h=%0d acc=%o",
               tag, instr_i, acc_i, link_i, res_valid_o, skip_o, halt_o, acc_o, ev, es, eh, ea);
    end
  endtask

  // One clock: drive at the falling edge, compare just after the rising edge
  task automatic step(input string tag, input bit stb, input int w, input int a, input int l);
    int sk, hl, ao;
    @(negedge clk);
    dec_stb = stb; instr_i = W'(w); acc_i = W'(a); link_i = 1'(l);
    model(w, a, l, sk, hl, ao);
    @(posedge clk);
    #1;
    if (stb) compare(tag, 1, sk, hl, ao);
    else     compare(tag, 0, 0, 0, 0);
  endtask

  initial begin
    // R2: reset dominates an active strobe
    dec_stb = 1'b1; instr_i = 12'o7412; acc_i = 12'o0; link_i = 1'b0;
    repeat (3) begin
      @(posedge clk); #1;
      compare("R2", 0, 0, 0, 0);
    end
    @(negedge clk); rst = 1'b0; dec_stb = 1'b0;

    step("R1", 0, 'o7410, 'o0, 0);
    step("R5", 1, 'o7440, 'o0, 0);
    step("R5", 1, 'o7440, 'o5, 0);
    step("R5", 1, 'o7450, 'o5, 0);
    step("R6", 1, 'o7420, 'o3, 1);
    step("R6", 1, 'o7430, 'o3, 0);
    step("R6", 1, 'o7430, 'o3, 1);
    step("R4", 1, 'o7500, 'o4000, 0);
    step("R4", 1, 'o7510, 'o4000, 0);
    step("R4", 1, 'o7510, 'o3777, 0);
    step("R8", 1, 'o7410, 'o1234, 1);
    step("R8", 1, 'o7400, 'o0, 0);
    step("R7", 1, 'o7560, 'o0001, 1);
    step("R7", 1, 'o7540, 'o0001, 0);
    step("R10", 1, 'o7402, 'o0, 0);
    step("R10", 1, 'o7412, 'o77, 1);
    step("R9", 1, 'o7640, 'o0, 0);
    step("R9", 1, 'o7700, 'o4321, 0);
    step("R9", 1, 'o7600, 'o17, 1);
    step("R3", 1, 'o1440, 'o0, 0);
    step("R3", 1, 'o7040, 'o0, 0);
    step("R3", 1, 'o7441, 'o0, 0);
    step("R3", 1, 'o7444, 'o0, 0);
    step("R1", 0, 'o7440, 'o0, 0);
    // R11: clear, then two tests on consecutive cycles with no clear between
    step("R11", 1, 'o7600, 'o5555, 0);
    step("R11", 1, 'o7440, 'o0, 0);
    step("R11", 1, 'o7430, 'o0, 0);
    step("R11", 1, 'o7402, 'o0, 0);
    step("R1", 0, 'o0, 'o0, 0);

    // R7: sweep every test/sense combination, with and without clear
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        for (int l = 0; l < 2; l++) begin
          int a;
          a = (k == 0) ? 'o0 : (k == 1) ? 'o1 : (k == 2) ? 'o4000 : 'o7777;
          step("R7", 1, 'o7400 + c * 8 + ((c + l) % 2) * 128, a, l);
        end
      end
    end
    step("R1", 0, 'o0, 'o0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule